// File: doc/BRIEF.md
# Pre-Trigger Waveform Capture Controller

This block turns a paced stream of samples from one channel into a capture that is centred on a rising-edge event. Each accepted sample goes to a circular buffer through a simple write port. The buffer write address starts at zero on a start command and wraps modulo the buffer depth. The trigger logic stays blind until one complete pass of the buffer has been written, so that valid history always precedes the event.

Triggering takes two steps. A sample must first drop strictly below an arm level. A later sample must then rise strictly above a separate fire level. The gap between the two levels gives hysteresis. When the trigger fires, a one-shot counter lets half a buffer of further samples be written and then stops all writes. The block records the buffer address at which the trigger happened, so that downstream logic can rotate the buffer and align the display to the event. A force input fires the trigger at once, without the arm step, for free-running modes. A done flag marks the halted capture.

Top module: `pretrig_capture`

## Requirements
- R1: While capturing, each sample presented with `smp_valid_i` high raises `wr_en_o` in the same cycle and appears unchanged on `wr_data_o`. The sample is written at `wr_addr_o`, which is 0 for the first sample after a start and then advances by one (modulo DEPTH) for every write. Outside capture, or in a cycle with start or stop high, `wr_en_o` is 0.
- R2: No trigger, including a forced one, is taken before DEPTH samples have been written since the last start. Fill-phase samples do not arm the trigger.
- R3: Once the fill has finished, a sample arms the trigger only when it is strictly below `arm_level_i`. A sample equal to the arm level does not arm.
- R4: An armed trigger fires on a later sample strictly above `fire_level_i`. A sample equal to the fire level does not fire, and the sample that arms cannot fire in the same cycle. Samples at or between the levels leave the trigger armed.
- R5: On the trigger cycle, `trig_index_o` captures the current write address: either the address of the trigger sample, or for a force in a cycle with no sample, the address of the next write. `trig_seen_o` rises in the next cycle. Both hold until the next start.
- R6: After a trigger the last sample written is the one at address `trig_index_o + DEPTH/2` (modulo DEPTH). No further writes occur after it.
- R7: `force_trig_i` high during the search phase (after the fill) fires the trigger in that cycle whether or not the trigger is armed.
- R8: `done_o` rises in the cycle after the last post-trigger write, with `busy_o` low. It stays high until a start command.
- R9: `start_i` in any state restarts the fill phase. In the next cycle `busy_o` is 1, `wr_addr_o` is 0, and `done_o` and `trig_seen_o` are 0.
- R10: `stop_i` without start while capturing returns the block to idle. `busy_o` goes low, `done_o` stays 0, and no further writes occur.
- R11: After reset `busy_o`, `done_o`, `trig_seen_o` and `wr_en_o` are 0 and `wr_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin (or restart) a capture from the fill phase |
| stop_i | input | 1 | Abort a running capture |
| force_trig_i | input | 1 | Fire the trigger without arming (search phase only) |
| arm_level_i | input | DATA_W | Arm when a sample is strictly below this |
| fire_level_i | input | DATA_W | Fire when an armed sample is strictly above this |
| smp_valid_i | input | 1 | Sample strobe from the pacing timer |
| smp_data_i | input | DATA_W | Sample value |
| wr_en_o | output | 1 | Buffer write enable |
| wr_addr_o | output | log2(DEPTH) | Buffer write address |
| wr_data_o | output | DATA_W | Buffer write data |
| busy_o | output | 1 | Capture in progress |
| done_o | output | 1 | Capture halted after a trigger |
| trig_seen_o | output | 1 | Trigger has fired in this capture |
| trig_index_o | output | log2(DEPTH) | Write address latched on trigger |

## Verification
The bench sweeps the trigger position over every buffer offset and more than one wrap, with several hysteresis dwell lengths, and checks for each run that the latched index and the final write address are exact. It feeds samples exactly at the arm and fire levels: a design that used non-strict comparisons would arm early and fire on an interposed high sample. It sends low samples and a force during the fill: a design that armed too soon would fire on the first high sample after the fill. It forces a trigger in a cycle with no sample, where a counter off by one would write one sample too few or too many. It also checks that start and stop mid-capture clear the state, and that a halted capture ignores further samples.

// File: rtl/pcap_pkg.sv
// Shared types for the pre-trigger capture controller.
// Assumes: nothing beyond the phase encoding used by the top FSM.
package pcap_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,   // waiting for start
        PH_FILL = 3'd1,   // first pass through buffer, trigger blind
        PH_HUNT = 3'd2,   // looking for arm then fire
        PH_POST = 3'd3,   // one-shot post-trigger fill
        PH_HALT = 3'd4    // capture frozen, done flag up
    } phase_t;

endpackage

// File: rtl/pcap_ring_ptr.sv
// Circular write pointer for the capture buffer.
// Advances by one per accepted sample, wraps modulo DEPTH, and flags the
// write that lands on the last address. Assumes DEPTH is a power of two.
module pcap_ring_ptr #(
    parameter int DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     adv_i,
    output logic [$clog2(DEPTH)-1:0] ptr_o,
    output logic                     wrap_o
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] ptr_q;

    // Pointer register: zero on clear, increment on each write.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            ptr_q <= '0;
        end else if (adv_i) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr_o  = ptr_q;
    assign wrap_o = adv_i && (ptr_q == LAST);

endmodule

// File: rtl/pcap_edge_trig.sv
// Two-step rising-edge trigger: arm on a sample strictly below the arm
// level, then fire on a later sample strictly above the fire level.
// A force input fires at once when enabled. Comparison signedness is
// picked by parameter. Assumes the caller gates en_i to the search phase.
module pcap_edge_trig #(
    parameter int DATA_W     = 12,
    parameter bit SIGNED_CMP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              en_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] arm_lvl_i,
    input  logic [DATA_W-1:0] fire_lvl_i,
    input  logic              force_i,
    output logic              fire_o
);
    logic below_arm;
    logic above_fire;
    logic armed_q;

    generate
        if (SIGNED_CMP) begin : g_signed
            assign below_arm  = $signed(data_i) < $signed(arm_lvl_i);
            assign above_fire = $signed(data_i) > $signed(fire_lvl_i);
        end else begin : g_unsigned
            assign below_arm  = data_i < arm_lvl_i;
            assign above_fire = data_i > fire_lvl_i;
        end
    endgenerate

    // Arm latch: set by a low sample while searching, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            armed_q <= 1'b0;
        end else if (en_i && valid_i && !armed_q && below_arm) begin
            armed_q <= 1'b1;
        end
    end

    assign fire_o = en_i && (force_i || (armed_q && valid_i && above_fire));

endmodule

// File: rtl/pcap_oneshot.sv
// One-shot down counter for the post-trigger window.
// Loaded with the number of writes still allowed; expire_o marks the tick
// that consumes the final count. Assumes load and tick never coincide.
module pcap_oneshot #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    // Remaining-writes counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = tick_i && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pretrig_capture.sv
// Pre-trigger waveform capture controller.
// Writes paced samples into a circular buffer, keeps the trigger blind for
// one full pass, searches for a low-then-high crossing (or a force), then
// writes half a buffer more and halts with the trigger address latched.
// Assumes DEPTH is a power of two >= 2 and fire level >= arm level.
module pretrig_capture #(
    parameter int DATA_W     = 12,
    parameter int DEPTH      = 1024,
    parameter bit SIGNED_CMP = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     stop_i,
    input  logic                     force_trig_i,
    input  logic [DATA_W-1:0]        arm_level_i,
    input  logic [DATA_W-1:0]        fire_level_i,
    input  logic                     smp_valid_i,
    input  logic [DATA_W-1:0]        smp_data_i,
    output logic                     wr_en_o,
    output logic [$clog2(DEPTH)-1:0] wr_addr_o,
    output logic [DATA_W-1:0]        wr_data_o,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     trig_seen_o,
    output logic [$clog2(DEPTH)-1:0] trig_index_o
);
    import pcap_pkg::*;

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = ADDR_W + 1;
    localparam int HALF   = DEPTH / 2;
    localparam logic [CNT_W-1:0] LOAD_WITH_SMP = CNT_W'(HALF);
    localparam logic [CNT_W-1:0] LOAD_NO_SMP   = CNT_W'(HALF + 1);

    phase_t            phase_q;
    phase_t            phase_d;
    logic              running;
    logic              ctl_quiet;
    logic              we;
    logic              hunt_en;
    logic              fire;
    logic              expire;
    logic              pass_done;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] trig_idx_q;
    logic              trig_seen_q;
    logic              done_q;
    logic [CNT_W-1:0]  post_load;

    assign running   = (phase_q == PH_FILL) || (phase_q == PH_HUNT) || (phase_q == PH_POST);
    assign ctl_quiet = !start_i && !stop_i;
    assign we        = smp_valid_i && running && ctl_quiet;
    assign hunt_en   = (phase_q == PH_HUNT) && ctl_quiet;
    assign post_load = we ? LOAD_WITH_SMP : LOAD_NO_SMP;

    pcap_ring_ptr #(
        .DEPTH (DEPTH)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .adv_i   (we),
        .ptr_o   (ptr),
        .wrap_o  (pass_done)
    );

    pcap_edge_trig #(
        .DATA_W     (DATA_W),
        .SIGNED_CMP (SIGNED_CMP)
    ) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .en_i       (hunt_en),
        .valid_i    (smp_valid_i),
        .data_i     (smp_data_i),
        .arm_lvl_i  (arm_level_i),
        .fire_lvl_i (fire_level_i),
        .force_i    (force_trig_i),
        .fire_o     (fire)
    );

    pcap_oneshot #(
        .CNT_W (CNT_W)
    ) u_post (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .load_i     (fire),
        .load_val_i (post_load),
        .tick_i     (we && (phase_q == PH_POST)),
        .expire_o   (expire)
    );

    // Next-phase selection: start wins, stop aborts, else sequence forward.
    always_comb begin
        phase_d = phase_q;
        if (start_i) begin
            phase_d = PH_FILL;
        end else if (stop_i && running) begin
            phase_d = PH_IDLE;
        end else begin
            case (phase_q)
                PH_FILL: if (pass_done) phase_d = PH_HUNT;
                PH_HUNT: if (fire)      phase_d = PH_POST;
                PH_POST: if (expire)    phase_d = PH_HALT;
                default: phase_d = phase_q;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Trigger bookkeeping: flag and address latched on the fire cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            trig_seen_q <= 1'b0;
            trig_idx_q  <= '0;
        end else if (fire) begin
            trig_seen_q <= 1'b1;
            trig_idx_q  <= ptr;
        end
    end

    // Done flag: set as the post window closes, held until a start.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            done_q <= 1'b0;
        end else if ((phase_q == PH_POST) && expire && !stop_i) begin
            done_q <= 1'b1;
        end
    end

    assign wr_en_o      = we;
    assign wr_addr_o    = ptr;
    assign wr_data_o    = smp_data_i;
    assign busy_o       = running;
    assign done_o       = done_q;
    assign trig_seen_o  = trig_seen_q;
    assign trig_index_o = trig_idx_q;

endmodule

// File: rtl/pretrig_capture_chk.sv
// Property checker for pretrig_capture, attached by bind.
// Observes ports only; assumes the synchronous active-low reset.
module pretrig_capture_chk #(
    parameter int DEPTH = 1024
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_i,
    input logic                     stop_i,
    input logic                     wr_en_o,
    input logic [$clog2(DEPTH)-1:0] wr_addr_o,
    input logic                     busy_o,
    input logic                     done_o,
    input logic                     trig_seen_o,
    input logic [$clog2(DEPTH)-1:0] trig_index_o
);
    localparam int ADDR_W = $clog2(DEPTH);

    // R1
    we_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> busy_o);

    // R1
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (wr_addr_o == ADDR_W'($past(wr_addr_o) + 1'b1)));

    // R5
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_seen_o && !start_i) |=> (trig_seen_o && $stable(trig_index_o)));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8
    done_after_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> trig_seen_o);

    // R9
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && !done_o && !trig_seen_o && (wr_addr_o == '0)));

    // R10
    stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i && busy_o) |=> (!busy_o && !done_o));

endmodule

bind pretrig_capture pretrig_capture_chk #(
    .DEPTH (DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .wr_en_o      (wr_en_o),
    .wr_addr_o    (wr_addr_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .trig_seen_o  (trig_seen_o),
    .trig_index_o (trig_index_o)
);

// File: tb/pretrig_capture_test.sv
module pretrig_capture_test;
    localparam int DW   = 8;
    localparam int DEP  = 8;
    localparam int AW   = 3;
    localparam int HALF = DEP / 2;
    localparam int LOWV  = 10;
    localparam int ARMV  = 50;
    localparam int MIDV  = 100;
    localparam int FIREV = 150;
    localparam int HIGHV = 200;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          start_i, stop_i, force_trig_i, smp_valid_i;
    logic [DW-1:0] arm_level_i, fire_level_i, smp_data_i;
    logic          wr_en_o, busy_o, done_o, trig_seen_o;
    logic [AW-1:0] wr_addr_o, trig_index_o;
    logic [DW-1:0] wr_data_o;

    pretrig_capture #(.DATA_W(DW), .DEPTH(DEP)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .force_trig_i(force_trig_i), .arm_level_i(arm_level_i),
        .fire_level_i(fire_level_i), .smp_valid_i(smp_valid_i),
        .smp_data_i(smp_data_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o),
        .trig_seen_o(trig_seen_o), .trig_index_o(trig_index_o)
    );

    int n_run = 0;
    int n_bad = 0;
    int eptr  = 0;
    bit running = 1'b0;

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(bit v, int d, bit f, bit st, bit sp);
        @(negedge clk);
        smp_valid_i  = v;
        smp_data_i   = d[DW-1:0];
        force_trig_i = f;
        start_i      = st;
        stop_i       = sp;
        #1;
    endtask

    task automatic feedf(int d, bit f, string tag);
        drive(1'b1, d, f, 1'b0, 1'b0);
        chk({tag, " R1 wr_en"}, int'(wr_en_o), int'(running));
        if (running) begin
            chk({tag, " R1 addr"}, int'(wr_addr_o), eptr);
            chk({tag, " R1 data"}, int'(wr_data_o), d);
            eptr = (eptr + 1) % DEP;
        end
    endtask

    task automatic feed(int d, string tag);
        feedf(d, 1'b0, tag);
    endtask

    task automatic idle();
        drive(1'b0, 0, 1'b0, 1'b0, 1'b0);
        chk("R1 gap wr_en", int'(wr_en_o), 0);
    endtask

    task automatic do_start();
        drive(1'b0, 0, 1'b0, 1'b1, 1'b0);
        chk("R1 start cycle wr_en", int'(wr_en_o), 0);
        eptr = 0;
        running = 1'b1;
        idle();
        chk("R9 busy", int'(busy_o), 1);
        chk("R9 done", int'(done_o), 0);
        chk("R9 trig_seen", int'(trig_seen_o), 0);
        chk("R9 addr", int'(wr_addr_o), 0);
    endtask

    task automatic fill(int v);
        for (int i = 0; i < DEP; i++) begin
            feed(v, "R2 fill");
            if (i % 3 == 2) idle();
        end
    endtask

    // Post-trigger window of n writes, then halt checks.
    task automatic post_window(int n, int exp_idx, string tag);
        for (int j = 0; j < n; j++) begin
            if (j == n - 1) running = 1'b0;
            running = 1'b1;
            feed(MIDV, "R6 post");
            chk({tag, " R5 trig_seen"}, int'(trig_seen_o), 1);
            chk({tag, " R5 index"}, int'(trig_index_o), exp_idx);
            chk({tag, " R8 done early"}, int'(done_o), 0);
        end
        running = 1'b0;
        chk({tag, " R6 last addr"}, (eptr + DEP - 1) % DEP, (exp_idx + HALF) % DEP);
        idle();
        chk({tag, " R8 done"}, int'(done_o), 1);
        chk({tag, " R8 busy"}, int'(busy_o), 0);
        feed(MIDV, "R6 halted");
        idle();
        feed(LOWV, "R6 halted");
        chk({tag, " R8 done held"}, int'(done_o), 1);
        chk({tag, " R5 index held"}, int'(trig_index_o), exp_idx);
    endtask

    task automatic run_edge(int p, int q);
        int exp_idx;
        do_start();
        fill(LOWV);
        feed(HIGHV, "R2 no arm in fill");
        for (int i = 0; i < p; i++) feed(ARMV, "R3 equal arm");
        feed(HIGHV, "R3 not armed");
        feed(LOWV, "R3 arm");
        for (int i = 0; i < q; i++) feed(MIDV, "R4 hysteresis");
        feed(FIREV, "R4 equal fire");
        exp_idx = eptr;
        chk("R4 arithmetic index", exp_idx, (p + q + 4) % DEP);
        feed(HIGHV, "R4 fire");
        chk("R4 no early trigger", int'(trig_seen_o), 0);
        post_window(HALF, exp_idx, "edge");
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        int exp_idx;
        rst_n = 1'b0;
        start_i = 0; stop_i = 0; force_trig_i = 0; smp_valid_i = 0;
        smp_data_i = '0;
        arm_level_i  = DW'(ARMV);
        fire_level_i = DW'(FIREV);
        repeat (3) @(posedge clk);
        #1;
        smp_valid_i = 1'b1;
        #1;
        chk("R11 busy", int'(busy_o), 0);
        chk("R11 done", int'(done_o), 0);
        chk("R11 trig_seen", int'(trig_seen_o), 0);
        chk("R11 wr_en", int'(wr_en_o), 0);
        chk("R11 addr", int'(wr_addr_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        smp_valid_i = 1'b0;

        // Sweep trigger position over more than one wrap and dwell lengths.
        for (int p = 0; p <= DEP + 1; p++) begin
            for (int q = 0; q < 3; q++) begin
                run_edge(p, q);
            end
        end

        // R7 force with no sample in the cycle.
        do_start();
        fill(LOWV);
        for (int i = 0; i < 3; i++) feed(MIDV, "R7 pre");
        exp_idx = eptr;
        drive(1'b0, 0, 1'b1, 1'b0, 1'b0);
        chk("R7 force no sample wr_en", int'(wr_en_o), 0);
        post_window(HALF + 1, exp_idx, "R7 force idle");

        // R7 force together with a sample.
        do_start();
        fill(MIDV);
        feed(MIDV, "R7 pre");
        feed(MIDV, "R7 pre");
        exp_idx = eptr;
        feedf(MIDV, 1'b1, "R7 force sample");
        post_window(HALF, exp_idx, "R7 force sample");

        // R2 force during fill is ignored, then R10 stop.
        do_start();
        feed(LOWV, "R2 fill");
        feed(LOWV, "R2 fill");
        feedf(HIGHV, 1'b1, "R2 force in fill");
        feed(LOWV, "R2 fill");
        chk("R2 force ignored in fill", int'(trig_seen_o), 0);
        drive(1'b1, MIDV, 1'b0, 1'b0, 1'b1);
        chk("R10 stop cycle wr_en", int'(wr_en_o), 0);
        running = 1'b0;
        idle();
        chk("R10 busy", int'(busy_o), 0);
        chk("R10 done", int'(done_o), 0);
        feed(MIDV, "R10 after stop");

        // R9 restart during the post window.
        do_start();
        fill(LOWV);
        feed(LOWV, "R3 arm");
        feed(HIGHV, "R4 fire");
        feed(MIDV, "R6 post");
        chk("R9 pre-restart trig_seen", int'(trig_seen_o), 1);
        do_start();
        feed(MIDV, "R9 restart fill");
        drive(1'b0, 0, 1'b0, 1'b0, 1'b1);
        running = 1'b0;
        idle();
        chk("R10 busy after stop", int'(busy_o), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule